// File: doc/BRIEF.md
# Double-Buffered Nibble-Loaded DAC Code Register

This block is the digital front end of a 12-bit converter. A host writes the code through an 8-bit parallel bus using an active-low chip select, an active-low write strobe and a 2-bit address. The address picks which of three 4-bit input holding registers take bus data: low, middle or high. A 4-bit host writes the word as three nibbles. An 8-bit host writes one byte that covers the low and middle nibbles, and then one nibble for the high part. The high nibble is read from the same four bus pins that carry the low nibble.

A second rank, the converter code register, takes all twelve holding bits in one step under an active-low load strobe. While the synchronized load strobe is low, the second rank tracks the first rank. On the strobe's rising edge it takes one final copy and then holds. With the strobe kept high, nibble writes can arrive in any order and the output does not move until the strobe is pulsed.

A clear input and an asynchronous power-on reset both zero both ranks. Clear wins over any write or load in the same cycle. All bus strobes are sampled in the system clock domain.

Top module: `nibble_dac_reg`

## Requirements
- R1: After `rst_n` is asserted, `dac_code` reads 0 and all holding nibbles are 0.
- R2: A holding register captures only on a clock in which `wr_n` is sampled high after being sampled low on the previous clock, with `cs_n` sampled low. A strobe with `cs_n` high changes nothing.
- R3: The address decode works as follows. `addr`=2'b00 loads code bits 7:0 from `data[7:0]`. 2'b01 loads bits 3:0 from `data[3:0]`. 2'b10 loads bits 7:4 from `data[7:4]`. 2'b11 loads bits 11:8 from `data[3:0]`.
- R4: A write leaves every nibble that its address does not select unchanged.
- R5: While the synchronized `ldac_n` stays high, `dac_code` does not change, whatever writes occur.
- R6: While `ldac_n` is held low, `dac_code` follows the holding registers, with a lag of at most four clocks.
- R7: On a rising edge of `ldac_n`, `dac_code` takes the holding contents and then keeps them.
- R8: A clock with `clr_n` sampled low zeroes the holding registers and `dac_code` at that edge. This takes priority over a write or load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| clr_n | input | 1 | Synchronous clear of both ranks, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; capture on its release |
| addr | input | 2 | Nibble select for the write |
| data | input | 8 | Parallel data bus |
| ldac_n | input | 1 | Load strobe of the second rank, active low |
| dac_code | output | 12 | Code held in the converter register |

## Verification
The assertions assume that `addr`, `data` and `cs_n` are steady on the clock where the release of `wr_n` is sampled. They also assume that `ldac_n` is a level that may change at any time, because it passes through a synchronizer. The bench changes every input only at the falling clock edge. It holds address, data and chip select from one cycle before the write strobe falls until one cycle after it rises. It keeps each load pulse several clocks long, so the synchronizer always sees both the low level and the rising edge.

// File: rtl/nibble_dac_pkg.sv
package nibble_dac_pkg;

  typedef enum logic [1:0] {
    SEL_LOW_MID = 2'b00,
    SEL_LOW     = 2'b01,
    SEL_MID     = 2'b10,
    SEL_HIGH    = 2'b11
  } nib_sel_e;

  // one enable bit per holding nibble: [0]=low, [1]=middle, [2]=high
  function automatic logic [2:0] decode_sel(input logic [1:0] a);
    logic [2:0] en;
    case (nib_sel_e'(a))
      SEL_LOW_MID: en = 3'b011;
      SEL_LOW:     en = 3'b001;
      SEL_MID:     en = 3'b010;
      SEL_HIGH:    en = 3'b100;
      default:     en = 3'b000;
    endcase
    return en;
  endfunction

  // bus lane that feeds holding nibble idx: high reuses the low lane
  function automatic int unsigned lane_of(input int unsigned idx);
    return idx % 2;
  endfunction

endpackage

// File: rtl/nib_bus_capture.sv
module nib_bus_capture
  import nibble_dac_pkg::*;
#(
  parameter int NIB_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic [1:0]       addr,
  output logic             wr_evt,
  output logic [NIB_N-1:0] nib_en
);

  logic wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_n;
  end

  // release of the write strobe while selected
  assign wr_evt = wr_n & ~wr_q & ~cs_n;

  always_comb begin
    nib_en = '0;
    if (wr_evt) nib_en = NIB_N'(decode_sel(addr));
  end

endmodule

// File: rtl/nib_hold_regs.sv
module nib_hold_regs
  import nibble_dac_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int NIB_N = 3,
  localparam int BUS_W = 2 * NIB_W,
  localparam int CODE_W = NIB_N * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic [NIB_N-1:0]  nib_en,
  input  logic [BUS_W-1:0]  data,
  output logic [CODE_W-1:0] word
);

  for (genvar i = 0; i < NIB_N; i++) begin : g_nib
    localparam int LANE = lane_of(i);
    logic [NIB_W-1:0] nib_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         nib_q <= '0;
      else if (!clr_n)    nib_q <= '0;
      else if (nib_en[i]) nib_q <= data[LANE*NIB_W +: NIB_W];
    end
    assign word[i*NIB_W +: NIB_W] = nib_q;
  end

endmodule

// File: rtl/nib_load_ctrl.sv
module nib_load_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ldac_n,
  output logic ldac_s,
  output logic ldac_rise
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ldac_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], ldac_n};
  end

  assign ldac_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ldac_d <= 1'b1;
    else        ldac_d <= ldac_s;
  end

  assign ldac_rise = ldac_s & ~ldac_d;

endmodule

// File: rtl/nibble_dac_reg.sv
module nibble_dac_reg #(
  parameter int NIB_W = 4,
  parameter int NIB_N = 3,
  parameter int SYNC_STAGES = 2,
  localparam int BUS_W = 2 * NIB_W,
  localparam int CODE_W = NIB_N * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  data,
  input  logic              ldac_n,
  output logic [CODE_W-1:0] dac_code
);

  logic              wr_evt;
  logic [NIB_N-1:0]  nib_en;
  logic [CODE_W-1:0] latch_word;
  logic              ldac_s;
  logic              ldac_rise;
  logic              dac_upd;

  nib_bus_capture #(.NIB_N(NIB_N)) u_cap (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .wr_evt(wr_evt), .nib_en(nib_en)
  );

  nib_hold_regs #(.NIB_W(NIB_W), .NIB_N(NIB_N)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .nib_en(nib_en),
    .data(data), .word(latch_word)
  );

  nib_load_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_load (
    .clk(clk), .rst_n(rst_n), .ldac_n(ldac_n),
    .ldac_s(ldac_s), .ldac_rise(ldac_rise)
  );

  // transparent while low, one last copy on the rising edge
  assign dac_upd = ~ldac_s | ldac_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dac_code <= '0;
    else if (!clr_n)  dac_code <= '0;
    else if (dac_upd) dac_code <= latch_word;
  end

endmodule

// File: rtl/nibble_dac_chk.sv
module nibble_dac_chk #(
  parameter int NIB_W = 4,
  parameter int NIB_N = 3,
  localparam int BUS_W = 2 * NIB_W,
  localparam int CODE_W = NIB_N * NIB_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic [BUS_W-1:0]  data,
  input logic              wr_evt,
  input logic [NIB_N-1:0]  nib_en,
  input logic [CODE_W-1:0] latch_word,
  input logic              ldac_s,
  input logic              ldac_rise,
  input logic [CODE_W-1:0] dac_code
);

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_ZERO: assert (dac_code == '0); // R1
  end

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |-> nib_en == '0); // R2

  AST_HIGH_FROM_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_en[NIB_N-1] && clr_n) |=>
      latch_word[CODE_W-1 -: NIB_W] == $past(data[NIB_W-1:0])); // R3

  AST_LOW_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!nib_en[0] && clr_n) |=> $stable(latch_word[NIB_W-1:0])); // R4

  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ldac_s && !ldac_rise) |=> $stable(dac_code)); // R5

  AST_FOLLOW_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ldac_s) |=> dac_code == $past(latch_word)); // R6

  AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ldac_rise) |=> dac_code == $past(latch_word)); // R7

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (dac_code == '0 && latch_word == '0)); // R8

endmodule

bind nibble_dac_reg nibble_dac_chk #(.NIB_W(NIB_W), .NIB_N(NIB_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .data(data), .wr_evt(wr_evt),
  .nib_en(nib_en), .latch_word(latch_word), .ldac_s(ldac_s),
  .ldac_rise(ldac_rise), .dac_code(dac_code)
);

// File: tb/test_nibble_dac_reg.sv
module test_nibble_dac_reg;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {addr[1:0], data[7:0], expected code after a load pulse}
  localparam logic [21:0] VEC [NVEC] = '{
    {2'b00, 8'hA5, 12'h0A5},
    {2'b11, 8'h3C, 12'hCA5},
    {2'b01, 8'hF7, 12'hCA7},
    {2'b10, 8'h9E, 12'hC97},
    {2'b11, 8'hF0, 12'h097},
    {2'b00, 8'hFF, 12'h0FF},
    {2'b11, 8'h0F, 12'hFFF},
    {2'b01, 8'h00, 12'hFF0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_n = 1'b1;
  logic        cs_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [1:0]  addr = 2'b00;
  logic [7:0]  data = 8'h00;
  logic        ldac_n = 1'b1;
  logic [11:0] dac_code;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nibble_dac_reg i_nibble_dac_reg (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
    .addr(addr), .data(data), .ldac_n(ldac_n), .dac_code(dac_code)
  );

  task automatic check(input string req, input logic [11:0] exp);
    checks++;
    if (dac_code !== exp) begin
      errors++;
      $display("FAIL %s: dac_code=%03h expected=%03h", req, dac_code, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d,
                           input logic sel_n, input logic clear_at_edge);
    @(negedge clk);
    cs_n = sel_n; addr = a; data = d;
    @(negedge clk);
    wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    if (clear_at_edge) clr_n = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
    cs_n = 1'b1;
  endtask

  task automatic pulse_load();
    @(negedge clk);
    ldac_n = 1'b0;
    repeat (4) @(negedge clk);
    ldac_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 12'h000);
    rst_n = 1'b1;
    idle(2);
    check("R1 after release", 12'h000);

    // table walk: one write then one load pulse per entry (R3, R7)
    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i][21:20], VEC[i][19:12], 1'b0, 1'b0);
      pulse_load();
      check($sformatf("R3 R7 vector %0d", i), VEC[i][11:0]);
    end

    // R5: writes with the load strobe high leave the output alone
    bus_write(2'b00, 8'h12, 1'b0, 1'b0);
    bus_write(2'b11, 8'h03, 1'b0, 1'b0);
    idle(5);
    check("R5 hold during writes", 12'hFF0);
    pulse_load();
    check("R7 load after writes", 12'h312);

    // R4: a low-nibble write spares middle and high
    bus_write(2'b01, 8'hEB, 1'b0, 1'b0);
    pulse_load();
    check("R4 other nibbles kept", 12'h31B);

    // R2: strobe with chip select high is ignored
    bus_write(2'b11, 8'h0F, 1'b1, 1'b0);
    bus_write(2'b00, 8'h00, 1'b1, 1'b0);
    pulse_load();
    check("R2 deselected write", 12'h31B);

    // R6: transparent mode, byte first then high nibble
    @(negedge clk);
    ldac_n = 1'b0;
    idle(4);
    bus_write(2'b00, 8'h44, 1'b0, 1'b0);
    idle(4);
    check("R6 follow byte", 12'h344);
    bus_write(2'b11, 8'h05, 1'b0, 1'b0);
    idle(4);
    check("R6 follow high", 12'h544);
    ldac_n = 1'b1;
    idle(5);
    bus_write(2'b01, 8'h00, 1'b0, 1'b0);
    idle(5);
    check("R7 held after rise", 12'h544);

    // R8: plain clear
    @(negedge clk);
    clr_n = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
    check("R8 clear output", 12'h000);
    pulse_load();
    check("R8 clear holding", 12'h000);

    // R8: clear on the same edge as a write release
    bus_write(2'b00, 8'h77, 1'b0, 1'b0);
    bus_write(2'b11, 8'h09, 1'b0, 1'b1);
    pulse_load();
    check("R8 clear beats write", 12'h000);

    // R8: clear while transparent beats the load
    bus_write(2'b00, 8'h5A, 1'b0, 1'b0);
    @(negedge clk);
    ldac_n = 1'b0;
    clr_n = 1'b0;
    idle(4);
    check("R8 clear beats load", 12'h000);
    clr_n = 1'b1;
    ldac_n = 1'b1;
    idle(5);

    // R1: reset in mid-use
    bus_write(2'b00, 8'h81, 1'b0, 1'b0);
    pulse_load();
    check("R7 before reset", 12'h081);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset in use", 12'h000);
    rst_n = 1'b1;
    pulse_load();
    check("R1 holding zeroed", 12'h000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run=expired expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule